// File: doc/BRIEF.md
# Machine/Supervisor CSR Legalising Write Unit

This block holds a small set of machine-level, supervisor-level and floating-point control and status registers for a 64-bit RISC-V core. Each access arrives on a single request port: the 12-bit CSR address, a 64-bit operand, a 2-bit operation code (read, write, set-bits or clear-bits), the current privilege and the encoding of the instruction that made the access. One clock later the response port returns the prior register value or an illegal-instruction trap with its trap value.

Every write passes through a legalising transform for its register. The value stored, the value later read back and the value reported in the trace are all taken from the same legal result. Two things follow from floating-point CSR writes. They mark the floating-point state dirty in the status register, and the status-register update appears as a second trace entry beside the primary one. Addresses with no register behind them never alias to a spare register. They trap, as do writes to read-only addresses and accesses above the current privilege.

Top module: `csr_warl_unit`

## Requirements
- R1: After synchronous active-low reset the response and trace outputs are zero. The machine status register reads 0x0000000A_00002000: floating-point state field (bits 14:13) = 01, both XLEN fields (bits 33:32 and 35:34) = 2, everything else zero.
- R2: The operation code is 00 read, 01 write, 10 set bits (old | operand) or 11 clear bits (old & ~operand). The response appears exactly one cycle after the request and returns the value held before the access.
- R3: A read, or a set/clear whose operand is zero, writes nothing and produces no trace entry. It does not trap on a read-only address either.
- R4: Bits 8, 4 and 0 always read zero in machine interrupt-enable (0x304), machine interrupt-pending (0x344), supervisor interrupt-enable (0x104) and supervisor interrupt-pending (0x144). Machine enable keeps bits 11,9,7,5,3,1. Machine pending accepts writes only to bits 9,5,1. Supervisor enable is bits 9,5,1 of machine enable. Supervisor pending reads bits 9,5,1 of machine pending and accepts writes only to bit 1.
- R5: Machine status (0x300) keeps bits 1,3,5,7,8,12:11,14:13. A write of 2'b10 to bits 12:11 leaves that field unchanged. Bit 63 reads 1 exactly when bits 14:13 are 11. Supervisor status (0x100) views and writes bits 1,5,8,14:13, and reads bits 33:32 as 2 and bit 63.
- R6: Exception delegation (0x302) keeps only the bits in mask 0xB3FF.
- R7: Flag CSR 0x001 is 5 bits, rounding-mode CSR 0x002 is 3 bits, and combined CSR 0x003 is {mode, flags}. Any write to one of them sets status bits 14:13 to 11.
- R8: Each performed write gives trace entry 0 with the accessed address and the new legal value. A floating-point CSR write also gives entry 1 with address 0x300 and the new machine status value.
- R9: An address with no register behind it traps (implemented: 0x001-0x003, 0x100, 0x104, 0x144, 0x300, 0x302, 0x304, 0x340, 0x344, and the read-only hart id 0xF14, which reads zero).
- R10: A performed write to an address whose bits 11:10 are 11 traps.
- R11: An access whose address bits 9:8 exceed the current privilege (0 user, 1 supervisor, 3 machine) traps.
- R12: A trap changes no register, produces no trace and returns zero data. Its trap value is the zero-extended instruction encoding. The trap value is zero on every other response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 12 | CSR address |
| req_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| req_operand | input | 64 | Source operand |
| req_priv | input | 2 | Current privilege |
| req_insn | input | 32 | Encoding of the accessing instruction |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Illegal-instruction trap |
| rsp_rdata | output | 64 | Value before the access |
| rsp_tval | output | 64 | Trap value |
| trc0_valid | output | 1 | Primary trace entry valid |
| trc0_addr | output | 12 | Primary updated CSR address |
| trc0_data | output | 64 | Primary new value |
| trc1_valid | output | 1 | Side-effect trace entry valid |
| trc1_addr | output | 12 | Side-effect CSR address |
| trc1_data | output | 64 | Side-effect new value |

## Verification
The bench targets the points where a legalising register file usually goes wrong. Writing all ones to every interrupt register shows whether user bits leak through. Writing 10 to the previous-privilege field catches a design that stores the illegal value. A floating-point flag write shows whether a design loses the dirty side effect or leaves it out of the trace. Zero-operand set/clear on the read-only hart id catches a design that traps where it should not. Unknown addresses, writes to read-only space and accesses from too low a privilege check that nothing is updated or traced and that the instruction appears as the trap value. Random mixes then compare every response against an independent model.

// File: rtl/csr_unit_pkg.sv
// Package: shared widths, addresses, legal-field masks and view helpers
// for the CSR legalising write unit. Assumes a 64-bit data path.
package csr_unit_pkg;

    localparam int XLEN   = 64;
    localparam int CSR_AW = 12;
    localparam int FS_LO  = 13;
    localparam int MPP_LO = 11;
    localparam int SD_BIT = XLEN - 1;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FFLAGS,
        SEL_FRM,
        SEL_FCSR,
        SEL_SSTATUS,
        SEL_SIE,
        SEL_SIP,
        SEL_MSTATUS,
        SEL_MEDELEG,
        SEL_MIE,
        SEL_MSCRATCH,
        SEL_MIP,
        SEL_HARTID
    } csr_sel_e;

    localparam logic [CSR_AW-1:0] A_FFLAGS   = 12'h001;
    localparam logic [CSR_AW-1:0] A_FRM      = 12'h002;
    localparam logic [CSR_AW-1:0] A_FCSR     = 12'h003;
    localparam logic [CSR_AW-1:0] A_SSTATUS  = 12'h100;
    localparam logic [CSR_AW-1:0] A_SIE      = 12'h104;
    localparam logic [CSR_AW-1:0] A_SIP      = 12'h144;
    localparam logic [CSR_AW-1:0] A_MSTATUS  = 12'h300;
    localparam logic [CSR_AW-1:0] A_MEDELEG  = 12'h302;
    localparam logic [CSR_AW-1:0] A_MIE      = 12'h304;
    localparam logic [CSR_AW-1:0] A_MSCRATCH = 12'h340;
    localparam logic [CSR_AW-1:0] A_MIP      = 12'h344;
    localparam logic [CSR_AW-1:0] A_HARTID   = 12'hF14;

    localparam logic [1:0] FS_INITIAL = 2'b01;
    localparam logic [1:0] FS_DIRTY   = 2'b11;
    localparam logic [1:0] MPP_RSVD   = 2'b10;

    localparam logic [XLEN-1:0] MSTATUS_WMASK = 64'h0000_0000_0000_79AA;
    localparam logic [XLEN-1:0] SSTATUS_WMASK = 64'h0000_0000_0000_6122;
    localparam logic [XLEN-1:0] MXL_FIELDS    = 64'h0000_000A_0000_0000;
    localparam logic [XLEN-1:0] UXL_FIELD     = 64'h0000_0002_0000_0000;
    localparam logic [XLEN-1:0] MIE_MASK      = 64'h0000_0000_0000_0AAA;
    localparam logic [XLEN-1:0] MIP_WMASK     = 64'h0000_0000_0000_0222;
    localparam logic [XLEN-1:0] S_IRQ_MASK    = 64'h0000_0000_0000_0222;
    localparam logic [XLEN-1:0] SIP_WMASK     = 64'h0000_0000_0000_0002;
    localparam logic [XLEN-1:0] USER_IRQ_BITS = 64'h0000_0000_0000_0111;
    localparam logic [XLEN-1:0] MEDELEG_MASK  = 64'h0000_0000_0000_B3FF;
    localparam logic [XLEN-1:0] STATUS_RESET  = 64'h0000_0000_0000_2000;

    // Machine view of the stored status bits, with fixed fields and summary bit.
    function automatic logic [XLEN-1:0] mstatus_view(input logic [XLEN-1:0] st);
        logic [XLEN-1:0] r;
        r = (st & MSTATUS_WMASK) | MXL_FIELDS;
        r[SD_BIT] = (st[FS_LO+1:FS_LO] == FS_DIRTY);
        return r;
    endfunction

    // Supervisor view of the stored status bits.
    function automatic logic [XLEN-1:0] sstatus_view(input logic [XLEN-1:0] st);
        logic [XLEN-1:0] r;
        r = (st & SSTATUS_WMASK) | UXL_FIELD;
        r[SD_BIT] = (st[FS_LO+1:FS_LO] == FS_DIRTY);
        return r;
    endfunction

    // Merge a write into the status bits under a field mask; reserved MPP keeps old.
    function automatic logic [XLEN-1:0] status_merge(input logic [XLEN-1:0] st,
                                                     input logic [XLEN-1:0] wr,
                                                     input logic [XLEN-1:0] mask);
        logic [XLEN-1:0] r;
        r = (st & ~mask) | (wr & mask);
        if (r[MPP_LO+1:MPP_LO] == MPP_RSVD) begin
            r[MPP_LO+1:MPP_LO] = st[MPP_LO+1:MPP_LO];
        end
        return r;
    endfunction

endpackage

// File: rtl/csr_decode.sv
// Module: csr_decode
// Maps a CSR address to a register selector and decides whether the access
// is illegal (unknown address, privilege too low, or a write to read-only
// space). Purely combinational; assumes priv encodings 0/1/3.
module csr_decode
    import csr_unit_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              writes_i,
    output csr_sel_e          sel_o,
    output logic              fp_o,
    output logic              illegal_o
);

    // Address to register selector.
    always_comb begin
        case (addr_i)
            A_FFLAGS:   sel_o = SEL_FFLAGS;
            A_FRM:      sel_o = SEL_FRM;
            A_FCSR:     sel_o = SEL_FCSR;
            A_SSTATUS:  sel_o = SEL_SSTATUS;
            A_SIE:      sel_o = SEL_SIE;
            A_SIP:      sel_o = SEL_SIP;
            A_MSTATUS:  sel_o = SEL_MSTATUS;
            A_MEDELEG:  sel_o = SEL_MEDELEG;
            A_MIE:      sel_o = SEL_MIE;
            A_MSCRATCH: sel_o = SEL_MSCRATCH;
            A_MIP:      sel_o = SEL_MIP;
            A_HARTID:   sel_o = SEL_HARTID;
            default:    sel_o = SEL_NONE;
        endcase
    end

    // Floating-point CSR flag and legality decision.
    always_comb begin
        fp_o      = (sel_o == SEL_FFLAGS) || (sel_o == SEL_FRM) || (sel_o == SEL_FCSR);
        illegal_o = (sel_o == SEL_NONE)
                 || (priv_i < addr_i[9:8])
                 || (writes_i && (addr_i[11:10] == 2'b11));
    end

endmodule

// File: rtl/csr_regs.sv
// Module: csr_regs
// Holds the architectural CSR state, forms the read-modify-write value,
// applies each register's legalising transform and returns both the old
// view and the new legal view of the selected register. State changes only
// when commit_i is high; the caller guarantees commit_i implies a legal write.
module csr_regs
    import csr_unit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  csr_sel_e        sel_i,
    input  csr_op_e         op_i,
    input  logic [XLEN-1:0] operand_i,
    output logic [XLEN-1:0] old_val_o,
    output logic [XLEN-1:0] new_val_o,
    output logic [XLEN-1:0] new_status_o
);

    logic [XLEN-1:0] status_q, mie_q, mip_q, deleg_q, scratch_q;
    logic [XLEN-1:0] status_d, mie_d, mip_d, deleg_d, scratch_d;
    logic [4:0]      flags_q, flags_d;
    logic [2:0]      rm_q, rm_d;
    logic [XLEN-1:0] merged;
    logic            fp_sel;

    // Read view of one register for a given state snapshot.
    function automatic logic [XLEN-1:0] csr_view(input csr_sel_e s,
                                                 input logic [XLEN-1:0] st,
                                                 input logic [XLEN-1:0] ie,
                                                 input logic [XLEN-1:0] ip,
                                                 input logic [XLEN-1:0] dl,
                                                 input logic [XLEN-1:0] sc,
                                                 input logic [4:0] ff,
                                                 input logic [2:0] rm);
        logic [XLEN-1:0] r;
        case (s)
            SEL_FFLAGS:   r = {{(XLEN-5){1'b0}}, ff};
            SEL_FRM:      r = {{(XLEN-3){1'b0}}, rm};
            SEL_FCSR:     r = {{(XLEN-8){1'b0}}, rm, ff};
            SEL_SSTATUS:  r = sstatus_view(st);
            SEL_SIE:      r = ie & S_IRQ_MASK;
            SEL_SIP:      r = ip & S_IRQ_MASK;
            SEL_MSTATUS:  r = mstatus_view(st);
            SEL_MEDELEG:  r = dl;
            SEL_MIE:      r = ie;
            SEL_MSCRATCH: r = sc;
            SEL_MIP:      r = ip;
            default:      r = '0;
        endcase
        return r;
    endfunction

    assign fp_sel    = (sel_i == SEL_FFLAGS) || (sel_i == SEL_FRM) || (sel_i == SEL_FCSR);
    assign old_val_o = csr_view(sel_i, status_q, mie_q, mip_q, deleg_q, scratch_q, flags_q, rm_q);

    // Combine the old value with the operand according to the operation.
    always_comb begin
        case (op_i)
            OP_SET:   merged = old_val_o | operand_i;
            OP_CLEAR: merged = old_val_o & ~operand_i;
            default:  merged = operand_i;
        endcase
    end

    // Legalised next state for the selected register.
    always_comb begin
        status_d  = status_q;
        mie_d     = mie_q;
        mip_d     = mip_q;
        deleg_d   = deleg_q;
        scratch_d = scratch_q;
        flags_d   = flags_q;
        rm_d      = rm_q;
        case (sel_i)
            SEL_FFLAGS:   flags_d = merged[4:0];
            SEL_FRM:      rm_d    = merged[2:0];
            SEL_FCSR:     {rm_d, flags_d} = merged[7:0];
            SEL_SSTATUS:  status_d  = status_merge(status_q, merged, SSTATUS_WMASK);
            SEL_MSTATUS:  status_d  = status_merge(status_q, merged, MSTATUS_WMASK);
            SEL_SIE:      mie_d     = (mie_q & ~S_IRQ_MASK) | (merged & S_IRQ_MASK);
            SEL_SIP:      mip_d     = (mip_q & ~SIP_WMASK) | (merged & SIP_WMASK);
            SEL_MIE:      mie_d     = merged & MIE_MASK;
            SEL_MIP:      mip_d     = (mip_q & ~MIP_WMASK) | (merged & MIP_WMASK);
            SEL_MEDELEG:  deleg_d   = merged & MEDELEG_MASK;
            SEL_MSCRATCH: scratch_d = merged;
            default: ;
        endcase
        if (fp_sel) begin
            status_d[FS_LO+1:FS_LO] = FS_DIRTY;
        end
    end

    assign new_val_o    = csr_view(sel_i, status_d, mie_d, mip_d, deleg_d, scratch_d, flags_d, rm_d);
    assign new_status_o = mstatus_view(status_d);

    // State registers: reset values, then update on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= STATUS_RESET;
            mie_q     <= '0;
            mip_q     <= '0;
            deleg_q   <= '0;
            scratch_q <= '0;
            flags_q   <= '0;
            rm_q      <= '0;
        end else if (commit_i) begin
            status_q  <= status_d;
            mie_q     <= mie_d;
            mip_q     <= mip_d;
            deleg_q   <= deleg_d;
            scratch_q <= scratch_d;
            flags_q   <= flags_d;
            rm_q      <= rm_d;
        end
    end

    AST_USER_IRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ((mie_q & USER_IRQ_BITS) == '0) && ((mip_q & USER_IRQ_BITS) == '0)); // R4
    AST_MPP_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n) status_q[MPP_LO+1:MPP_LO] != MPP_RSVD); // R5
    AST_FP_WRITE_DIRTIES: assert property (@(posedge clk) disable iff (!rst_n) (commit_i && fp_sel) |=> (status_q[FS_LO+1:FS_LO] == FS_DIRTY)); // R7
    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n) !commit_i |=> ($stable(status_q) && $stable(mie_q) && $stable(mip_q) && $stable(deleg_q) && $stable(scratch_q))); // R12

endmodule

// File: rtl/csr_warl_unit.sv
// Module: csr_warl_unit (top)
// Single request/response CSR access port. Decodes and checks the access,
// performs the legal read-modify-write in csr_regs and registers a response
// and a two-entry update trace one cycle after the request. Assumes at most
// one request per cycle and that the requester accepts every response.
module csr_warl_unit
    import csr_unit_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CSR_AW-1:0] req_addr,
    input  logic [1:0]        req_op,
    input  logic [XLEN-1:0]   req_operand,
    input  logic [1:0]        req_priv,
    input  logic [INSN_W-1:0] req_insn,
    output logic              rsp_valid,
    output logic              rsp_trap,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic [XLEN-1:0]   rsp_tval,
    output logic              trc0_valid,
    output logic [CSR_AW-1:0] trc0_addr,
    output logic [XLEN-1:0]   trc0_data,
    output logic              trc1_valid,
    output logic [CSR_AW-1:0] trc1_addr,
    output logic [XLEN-1:0]   trc1_data
);

    localparam int TVAL_PAD = XLEN - INSN_W;

    csr_op_e         op;
    csr_sel_e        sel;
    logic            writes, illegal, is_fp, commit, trap_now;
    logic [XLEN-1:0] old_val, new_val, new_status;

    // Operation decode: does this access actually write?
    always_comb begin
        op     = csr_op_e'(req_op);
        writes = (op == OP_WRITE) || (((op == OP_SET) || (op == OP_CLEAR)) && (|req_operand));
    end

    csr_decode u_decode (
        .addr_i    (req_addr),
        .priv_i    (req_priv),
        .writes_i  (writes),
        .sel_o     (sel),
        .fp_o      (is_fp),
        .illegal_o (illegal)
    );

    assign commit   = req_valid && !illegal && writes;
    assign trap_now = req_valid && illegal;

    csr_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit),
        .sel_i        (sel),
        .op_i         (op),
        .operand_i    (req_operand),
        .old_val_o    (old_val),
        .new_val_o    (new_val),
        .new_status_o (new_status)
    );

    // Response and trace registers, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_trap   <= 1'b0;
            rsp_rdata  <= '0;
            rsp_tval   <= '0;
            trc0_valid <= 1'b0;
            trc0_addr  <= '0;
            trc0_data  <= '0;
            trc1_valid <= 1'b0;
            trc1_addr  <= '0;
            trc1_data  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_trap   <= trap_now;
            rsp_rdata  <= (req_valid && !illegal) ? old_val : '0;
            rsp_tval   <= trap_now ? {{TVAL_PAD{1'b0}}, req_insn} : '0;
            trc0_valid <= commit;
            trc0_addr  <= commit ? req_addr : '0;
            trc0_data  <= commit ? new_val : '0;
            trc1_valid <= commit && is_fp;
            trc1_addr  <= (commit && is_fp) ? A_MSTATUS : '0;
            trc1_data  <= (commit && is_fp) ? new_status : '0;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
    AST_TRAP_NO_TRACE: assert property (@(posedge clk) disable iff (!rst_n) rsp_trap |-> (!trc0_valid && !trc1_valid)); // R12
    AST_TVAL_ONLY_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n) !rsp_trap |-> (rsp_tval == '0)); // R12
    AST_SIDE_ENTRY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) trc1_valid |-> (trc0_valid && trc1_data[SD_BIT] && (trc1_data[FS_LO+1:FS_LO] == FS_DIRTY))); // R8

endmodule

// File: tb/csr_warl_unit_test.sv
`timescale 1ns/1ps
module csr_warl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [11:0] req_addr;
    logic [1:0]  req_op;
    logic [63:0] req_operand;
    logic [1:0]  req_priv;
    logic [31:0] req_insn;
    logic        rsp_valid, rsp_trap, trc0_valid, trc1_valid;
    logic [63:0] rsp_rdata, rsp_tval, trc0_data, trc1_data;
    logic [11:0] trc0_addr, trc1_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    csr_warl_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_operand(req_operand), .req_priv(req_priv), .req_insn(req_insn),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_rdata(rsp_rdata), .rsp_tval(rsp_tval),
        .trc0_valid(trc0_valid), .trc0_addr(trc0_addr), .trc0_data(trc0_data),
        .trc1_valid(trc1_valid), .trc1_addr(trc1_addr), .trc1_data(trc1_data)
    );

    // Reference state, kept field by field.
    logic       s_sie, s_mie, s_spie, s_mpie, s_spp;
    logic [1:0] s_mpp, s_fs;
    logic [63:0] m_ie, m_ip, m_deleg, m_scr;
    logic [4:0] m_ff;
    logic [2:0] m_rm;

    function automatic logic [63:0] m_read(input logic [11:0] a, output logic ok);
        logic [63:0] r;
        r  = '0;
        ok = 1'b1;
        case (a)
            12'h001: r[4:0] = m_ff;
            12'h002: r[2:0] = m_rm;
            12'h003: r[7:0] = {m_rm, m_ff};
            12'h100: begin
                r[1] = s_sie; r[5] = s_spie; r[8] = s_spp; r[14:13] = s_fs;
                r[33:32] = 2'd2; r[63] = (s_fs == 2'b11);
            end
            12'h300: begin
                r[1] = s_sie; r[3] = s_mie; r[5] = s_spie; r[7] = s_mpie; r[8] = s_spp;
                r[12:11] = s_mpp; r[14:13] = s_fs; r[33:32] = 2'd2; r[35:34] = 2'd2;
                r[63] = (s_fs == 2'b11);
            end
            12'h104: r = m_ie & 64'h222;
            12'h144: r = m_ip & 64'h222;
            12'h302: r = m_deleg;
            12'h304: r = m_ie;
            12'h340: r = m_scr;
            12'h344: r = m_ip;
            12'hF14: r = '0;
            default: ok = 1'b0;
        endcase
        return r;
    endfunction

    task automatic m_write(input logic [11:0] a, input logic [63:0] v);
        case (a)
            12'h001: begin m_ff = v[4:0]; s_fs = 2'b11; end
            12'h002: begin m_rm = v[2:0]; s_fs = 2'b11; end
            12'h003: begin {m_rm, m_ff} = v[7:0]; s_fs = 2'b11; end
            12'h100: begin s_sie = v[1]; s_spie = v[5]; s_spp = v[8]; s_fs = v[14:13]; end
            12'h300: begin
                s_sie = v[1]; s_mie = v[3]; s_spie = v[5]; s_mpie = v[7]; s_spp = v[8];
                if (v[12:11] != 2'b10) s_mpp = v[12:11];
                s_fs = v[14:13];
            end
            12'h104: m_ie = (m_ie & ~64'h222) | (v & 64'h222);
            12'h144: m_ip = (m_ip & ~64'h2) | (v & 64'h2);
            12'h302: m_deleg = v & 64'hB3FF;
            12'h304: m_ie = v & 64'hAAA;
            12'h340: m_scr = v;
            12'h344: m_ip = (m_ip & ~64'h222) | (v & 64'h222);
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: model it, drive it at a falling edge, check the response one cycle later.
    task automatic run(input logic [11:0] a, input logic [1:0] op, input logic [63:0] v,
                       input logic [1:0] pv, input string tag);
        logic [63:0] old, nv, ns, raw;
        logic [31:0] insn;
        logic ok, ok2, wr, ill, fp;
        insn = $urandom;
        old  = m_read(a, ok);
        wr   = (op == 2'd1) || ((op != 2'd0) && (v != '0));
        ill  = !ok || (pv < a[9:8]) || (wr && (a[11:10] == 2'b11));
        fp   = (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
        raw  = (op == 2'd2) ? (old | v) : (op == 2'd3) ? (old & ~v) : v;
        if (!ill && wr) m_write(a, raw);
        nv = m_read(a, ok2);
        ns = m_read(12'h300, ok2);
        req_valid = 1'b1; req_addr = a; req_op = op; req_operand = v; req_priv = pv; req_insn = insn;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", {tag, " rsp_valid"}, {63'b0, rsp_valid}, 64'd1);
        check(tag, "rsp_trap", {63'b0, rsp_trap}, {63'b0, ill});
        check(tag, "rsp_rdata", rsp_rdata, ill ? 64'd0 : old);
        check("R12", {tag, " rsp_tval"}, rsp_tval, ill ? {32'b0, insn} : 64'd0);
        check("R8", {tag, " trc0_valid"}, {63'b0, trc0_valid}, {63'b0, (!ill && wr)});
        if (!ill && wr) begin
            check("R8", {tag, " trc0_addr"}, {52'b0, trc0_addr}, {52'b0, a});
            check(tag, "trc0_data", trc0_data, nv);
        end
        check("R8", {tag, " trc1_valid"}, {63'b0, trc1_valid}, {63'b0, (!ill && wr && fp)});
        if (!ill && wr && fp) begin
            check("R8", {tag, " trc1_addr"}, {52'b0, trc1_addr}, 64'h300);
            check("R7", {tag, " trc1_data"}, trc1_data, ns);
        end
    endtask

    function automatic string pick_tag(input logic [11:0] a, input logic [1:0] op,
                                       input logic [63:0] v, input logic [1:0] pv);
        logic ok;
        logic [63:0] unused_v;
        logic wr;
        unused_v = m_read(a, ok);
        wr = (op == 2'd1) || ((op != 2'd0) && (v != '0));
        if (!ok) return "R9";
        if (pv < a[9:8]) return "R11";
        if (wr && (a[11:10] == 2'b11)) return "R10";
        if (!wr) return "R3";
        if (a == 12'h001 || a == 12'h002 || a == 12'h003) return "R7";
        if (a == 12'h300 || a == 12'h100) return "R5";
        if (a == 12'h302) return "R6";
        if (a == 12'h304 || a == 12'h344 || a == 12'h104 || a == 12'h144) return "R4";
        return "R2";
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] addrs [12];
        void'($urandom(32'd7321));
        addrs = '{12'h001, 12'h002, 12'h003, 12'h100, 12'h104, 12'h144,
                  12'h300, 12'h302, 12'h304, 12'h340, 12'h344, 12'hF14};
        s_sie = 0; s_mie = 0; s_spie = 0; s_mpie = 0; s_spp = 0; s_mpp = 2'b00; s_fs = 2'b01;
        m_ie = '0; m_ip = '0; m_deleg = '0; m_scr = '0; m_ff = '0; m_rm = '0;
        req_valid = 0; req_addr = '0; req_op = '0; req_operand = '0; req_priv = 2'd3; req_insn = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state of the outputs and of the status register
        check("R1", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        check("R1", "trc0_valid after reset", {63'b0, trc0_valid}, 64'd0);
        run(12'h300, 2'd0, 64'd0, 2'd3, "R1");
        check("R1", "mstatus reset value", rsp_rdata, 64'h0000_000A_0000_2000);
        // R4: user interrupt bits stay zero
        run(12'h304, 2'd1, '1, 2'd3, "R4");
        check("R4", "mie all-ones write", trc0_data, 64'hAAA);
        run(12'h344, 2'd1, '1, 2'd3, "R4");
        check("R4", "mip all-ones write", trc0_data, 64'h222);
        run(12'h144, 2'd3, 64'h223, 2'd1, "R4");
        check("R4", "sip clear keeps bits 9,5", trc0_data, 64'h220);
        run(12'h104, 2'd1, 64'h111, 2'd1, "R4");
        // R5: reserved previous-privilege value is refused
        run(12'h300, 2'd1, 64'h1800, 2'd3, "R5");
        run(12'h300, 2'd1, 64'h1000, 2'd3, "R5");
        check("R5", "MPP after writing 10", {62'b0, trc0_data[12:11]}, 64'd3);
        run(12'h100, 2'd1, '1, 2'd1, "R5");
        // R6: delegation mask
        run(12'h302, 2'd1, '1, 2'd3, "R6");
        check("R6", "medeleg all-ones write", trc0_data, 64'hB3FF);
        // R7/R8: floating-point write dirties status and is traced
        run(12'h300, 2'd3, 64'h6000, 2'd3, "R5");
        run(12'h001, 2'd1, 64'h1F, 2'd0, "R7");
        check("R7", "status SD after fflags write", {63'b0, trc1_data[63]}, 64'd1);
        check("R8", "side entry present", {63'b0, trc1_valid}, 64'd1);
        run(12'h003, 2'd2, 64'hE0, 2'd0, "R7");
        // R3: zero-operand set/clear on read-only and scratch
        run(12'hF14, 2'd2, 64'd0, 2'd3, "R3");
        check("R3", "no trap on zero set of read-only", {63'b0, rsp_trap}, 64'd0);
        run(12'h340, 2'd3, 64'd0, 2'd3, "R3");
        // R10/R9/R11 traps
        run(12'hF14, 2'd1, 64'd5, 2'd3, "R10");
        run(12'h7C0, 2'd0, 64'd0, 2'd3, "R9");
        run(12'h300, 2'd0, 64'd0, 2'd1, "R11");
        run(12'h104, 2'd1, 64'h2, 2'd0, "R11");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [1:0]  op, pv;
            logic [63:0] v;
            a  = ($urandom % 8 == 0) ? 12'($urandom) : addrs[$urandom % 12];
            op = 2'($urandom);
            v  = ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom};
            pv = ($urandom % 4 == 0) ? 2'd0 : ($urandom % 3 == 0) ? 2'd1 : 2'd3;
            run(a, op, v, pv, pick_tag(a, op, v, pv));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule